// File: doc/BRIEF.md
# Timebase-Compare Watchdog

This block is a watchdog that has no counter of its own. It watches the high byte of a free-running 16-bit timebase that other logic shares. It holds an expiry byte and an offset byte. A kick is a write to the update strobe. A kick moves the expiry byte to the current timebase high byte plus the offset, so the timeout window is set by the offset, measured in steps of 256 timebase counts. If the timebase high byte reaches the expiry byte before the next kick, the block issues a one-cycle reset request for the system reset logic to act on.

The watchdog comes out of reset already running, with a defined expiry byte. Software that never kicks it therefore still gets a timeout. A write to the mode strobe turns the watchdog on or off. While it is on, write strobes aimed at the shared timebase configuration are blocked; the block passes such strobes on only while the watchdog is off. All pins are plain control and data pins with no handshake. Each strobe acts in the clock cycle in which it is high.

Top module: `tbcmp_watchdog`

## Requirements
- R1: After reset the watchdog is enabled, the offset is `RST_OFFSET` (default 0x00), the expiry byte is `RST_EXPIRY` (default 0xFF), and `wd_reset_req` is 0.
- R2: When enabled, the first cycle in which `tb_count[15:8]` equals the expiry byte makes `wd_reset_req` go high on the next clock edge.
- R3: `wd_reset_req` is high for exactly one cycle per match episode, even while the high byte keeps equalling the expiry byte.
- R4: A cycle with `kick_wr` high loads the expiry byte with (`tb_count[15:8]` + offset) modulo 256, wrapping past 0xFF.
- R5: A cycle with `offset_wr` high stores `offset_data` as the offset for later kicks and leaves the current expiry byte unchanged.
- R6: A kick in the same cycle as a match suppresses the reset request for that match.
- R7: A cycle with `mode_wr` high sets the enable to `mode_enable`, taking effect at the next clock; while disabled no reset request is issued.
- R8: `cfg_wr_pass` equals `cfg_wr` while the watchdog is disabled and is 0 while it is enabled.
- R9: `tb_count[7:0]` has no effect on matching; only the high byte is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | 16 | Shared timebase counter value |
| mode_wr | input | 1 | Strobe that writes the enable bit |
| mode_enable | input | 1 | New enable value, taken when `mode_wr` is high |
| offset_wr | input | 1 | Strobe that writes the offset byte |
| offset_data | input | 8 | New offset value |
| kick_wr | input | 1 | Update strobe; reloads the expiry byte |
| cfg_wr | input | 1 | Write strobe aimed at the timebase configuration |
| cfg_wr_pass | output | 1 | `cfg_wr` after gating by the enable |
| wd_reset_req | output | 1 | One-cycle reset request |

## Verification
The case that is hardest to reach is a kick that lands in exactly the first cycle where the high byte equals the expiry byte. With a real timebase this needs cycle-exact timing. Here the bench drives `tb_count` directly: it kicks once to place the expiry byte, then jumps the count onto that byte in the same cycle as a second kick. It checks that no request appears and that the next match moves to the new expiry byte. Wrapping of the offset sum past 0xFF is reached the same way, by kicking from a high count with a large offset.

// File: rtl/tbcmp_wdt_pkg.sv
package tbcmp_wdt_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t add_wrap(input byte_t a, input byte_t b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/tbcmp_wdt_ctrl.sv
module tbcmp_wdt_ctrl
  import tbcmp_wdt_pkg::*;
#(
  parameter byte_t RST_OFFSET = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_wr,
  input  logic  mode_enable,
  input  logic  offset_wr,
  input  byte_t offset_data,
  input  logic  cfg_wr,
  output logic  wd_en,
  output byte_t offset_q,
  output logic  cfg_wr_pass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en    <= 1'b1;
      offset_q <= RST_OFFSET;
    end else begin
      if (mode_wr)   wd_en    <= mode_enable;
      if (offset_wr) offset_q <= offset_data;
    end
  end

  assign cfg_wr_pass = cfg_wr & ~wd_en;

  assert_mode_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_wr) |-> (wd_en == $past(mode_enable)));
  assert_offset_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(offset_wr) |-> (offset_q == $past(offset_data)));
endmodule

// File: rtl/tbcmp_wdt_expiry.sv
module tbcmp_wdt_expiry
  import tbcmp_wdt_pkg::*;
#(
  parameter byte_t RST_EXPIRY = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wd_en,
  input  byte_t cnt_hi,
  input  byte_t offset_q,
  input  logic  kick_wr,
  output byte_t expiry_q,
  output logic  req_q
);
  logic hit, hit_d;

  assign hit = wd_en & (cnt_hi == expiry_q) & ~kick_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expiry_q <= RST_EXPIRY;
      hit_d    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (kick_wr) expiry_q <= add_wrap(cnt_hi, offset_q);
      hit_d <= hit;
      req_q <= hit & ~hit_d;
    end
  end

  assert_kick_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kick_wr) |-> (expiry_q == byte_t'($past(cnt_hi) + $past(offset_q))));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_req_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(cnt_hi) == $past(expiry_q)));
  assert_kick_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !$past(kick_wr));
endmodule

// File: rtl/tbcmp_watchdog.sv
module tbcmp_watchdog
  import tbcmp_wdt_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter byte_t       RST_OFFSET = 8'h00,
  parameter byte_t       RST_EXPIRY = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tb_count,
  input  logic             mode_wr,
  input  logic             mode_enable,
  input  logic             offset_wr,
  input  logic [7:0]       offset_data,
  input  logic             kick_wr,
  input  logic             cfg_wr,
  output logic             cfg_wr_pass,
  output logic             wd_reset_req
);
  localparam int unsigned HI_LSB = CNT_W - BYTE_W;

  logic  wd_en;
  byte_t offset_q, expiry_q, cnt_hi;

  assign cnt_hi = tb_count[CNT_W-1:HI_LSB];

  tbcmp_wdt_ctrl #(.RST_OFFSET(RST_OFFSET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_enable(mode_enable),
    .offset_wr(offset_wr), .offset_data(offset_data), .cfg_wr(cfg_wr),
    .wd_en(wd_en), .offset_q(offset_q), .cfg_wr_pass(cfg_wr_pass)
  );

  tbcmp_wdt_expiry #(.RST_EXPIRY(RST_EXPIRY)) u_expiry (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .cnt_hi(cnt_hi),
    .offset_q(offset_q), .kick_wr(kick_wr), .expiry_q(expiry_q),
    .req_q(wd_reset_req)
  );

  assert_no_req_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |-> $past(wd_en));
  assert_cfg_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_pass |-> (cfg_wr && !wd_en));
endmodule

// File: tb/sim_tbcmp_watchdog.sv
module sim_tbcmp_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tb_count = 16'h0000;
  logic        mode_wr = 1'b0, mode_enable = 1'b0;
  logic        offset_wr = 1'b0;
  logic [7:0]  offset_data = 8'h00;
  logic        kick_wr = 1'b0, cfg_wr = 1'b0;
  logic        cfg_wr_pass, wd_reset_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tbcmp_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .mode_wr(mode_wr),
    .mode_enable(mode_enable), .offset_wr(offset_wr), .offset_data(offset_data),
    .kick_wr(kick_wr), .cfg_wr(cfg_wr), .cfg_wr_pass(cfg_wr_pass),
    .wd_reset_req(wd_reset_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs were set at a negedge; advance to the next negedge
  task automatic step();
    @(negedge clk);
    mode_wr = 1'b0; offset_wr = 1'b0; kick_wr = 1'b0;
  endtask

  task automatic set_offset(input logic [7:0] v);
    offset_wr = 1'b1; offset_data = v; step();
  endtask

  task automatic kick_at(input logic [15:0] c);
    tb_count = c; kick_wr = 1'b1; step();
  endtask

  task automatic count_to(input logic [15:0] c);
    tb_count = c; step();
  endtask

  task automatic t_reset();
    check("R1 req low", wd_reset_req, 1'b0);
    cfg_wr = 1'b1; #1;
    check("R1/R8 enabled blocks cfg", cfg_wr_pass, 1'b0);
    cfg_wr = 1'b0;
  endtask

  task automatic t_first_timeout();
    count_to(16'hFE80);
    check("R1 no req before FF", wd_reset_req, 1'b0);
    count_to(16'hFF00);
    check("R2 req after first match", wd_reset_req, 1'b1);
    count_to(16'hFF55);
    check("R3 single pulse", wd_reset_req, 1'b0);
    count_to(16'hFFFF);
    check("R3 still single", wd_reset_req, 1'b0);
  endtask

  task automatic t_kick();
    count_to(16'h0000);
    set_offset(8'h10);
    kick_at(16'h3012);
    count_to(16'h3FFF);
    check("R4 no early req", wd_reset_req, 1'b0);
    count_to(16'h40C3);
    check("R4/R9 req at 0x40", wd_reset_req, 1'b1);
    step();
    check("R3 pulse ends", wd_reset_req, 1'b0);
  endtask

  task automatic t_wrap();
    count_to(16'h0000);
    set_offset(8'hF0);
    kick_at(16'h2000);
    count_to(16'h2000);
    check("R4 no req at old byte", wd_reset_req, 1'b0);
    count_to(16'h10FF);
    check("R4 wrapped expiry 0x10", wd_reset_req, 1'b1);
  endtask

  task automatic t_offset_only();
    count_to(16'h0000);
    set_offset(8'h05);
    kick_at(16'h6000);          // expiry 0x65
    set_offset(8'h30);          // must not move expiry
    count_to(16'h9500);
    check("R5 offset write leaves expiry", wd_reset_req, 1'b0);
    count_to(16'h6500);
    check("R5 expiry still 0x65", wd_reset_req, 1'b1);
  endtask

  task automatic t_kick_on_match();
    count_to(16'h0000);
    set_offset(8'h20);
    kick_at(16'h3000);          // expiry 0x50
    kick_at(16'h5000);          // lands on match, expiry -> 0x70
    check("R6 kick suppresses req", wd_reset_req, 1'b0);
    count_to(16'h5001);
    check("R6 old expiry gone", wd_reset_req, 1'b0);
    count_to(16'h7000);
    check("R6 new expiry 0x70", wd_reset_req, 1'b1);
  endtask

  task automatic t_disable();
    count_to(16'h0000);
    mode_wr = 1'b1; mode_enable = 1'b0; step();
    cfg_wr = 1'b1; #1;
    check("R8 disabled passes cfg", cfg_wr_pass, 1'b1);
    cfg_wr = 1'b0; #1;
    check("R8 no strobe no pass", cfg_wr_pass, 1'b0);
    count_to(16'h7000);
    check("R7 disabled no req", wd_reset_req, 1'b0);
    mode_wr = 1'b1; mode_enable = 1'b1; step();
    cfg_wr = 1'b1; #1;
    check("R7/R8 re-enabled blocks cfg", cfg_wr_pass, 1'b0);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_timeout();
    t_kick();
    t_wrap();
    t_offset_only();
    t_kick_on_match();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule